// File: doc/BRIEF.md
# Interrupt Request Tracker with One-Deep Pending Queue

This block tracks interrupt requests for a parameterized number of priority levels. Each level has three state bits: a request bit, an in-service bit and a pending bit that holds one queued request. Devices raise single-cycle request pulses per level. Each pulse is answered one cycle later with a status code that says whether the request was taken at once, held in the queue, or dropped. A level can also withdraw its request with a cancel pulse.

A consumer sees the pending-interrupt flag and the number of the selected level. The selected level is the lowest-numbered requested level that is not masked. An acknowledge pulse, allowed only while the global enable is high, moves that level from requested to in service. An end-of-interrupt pulse retires the lowest-numbered in-service level. A queued request moves into the request register by itself once its level is neither requested nor in service. This lets a device fire again during its own service routine without losing the event.

Top module: `irq_tracker`

## Requirements
- R1: A request pulse for a level whose request, in-service and pending bits are all clear sets that level's request bit. It reports status 1 (accepted) one cycle later. The status field of level k is bits [2k+1:2k] of `stat_o`, and it is 0 in a cycle with no request for that level.
- R2: A request pulse for a level whose request or in-service bit is set sets its pending bit. It reports status 2 (queued) if the pending bit was clear, and status 3 (lost) if it was already set.
- R3: A level holds at most one pending request. A request while one is pending changes neither the pending bit nor the request bit.
- R4: A pending bit whose level has neither request nor in-service set moves into the request register on the next clock, and the pending bit clears. Promotion therefore shows one cycle after the blocking in-service bit clears. A request arriving in the promotion cycle is judged against the promoted state, so it reports queued and refills the pending bit.
- R5: A cancel pulse clears the level's request and pending bits, and has no effect on a level where both are clear. A cancel wins over a request for the same level in the same cycle: nothing is recorded and the status is 0.
- R6: `irq_pending_o` is high when any unmasked request bit is set. `sel_level_o` gives the lowest-numbered such level. An acknowledge with enable high clears that level's request bit and sets its in-service bit. A level never has its request and in-service bits set together.
- R7: While `int_en_i` is low, an acknowledge has no effect, and `irq_pending_o` still reflects the unmasked requests.
- R8: An end-of-interrupt pulse clears the lowest-numbered set in-service bit, and does nothing when none is set.
- R9: A level with its `mask_i` bit high is neither flagged nor selected, and its request stays recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NUM_LEVELS | Per-level request pulses |
| cancel_i | input | NUM_LEVELS | Per-level cancel pulses |
| mask_i | input | NUM_LEVELS | Per-level mask, 1 blocks the level |
| int_en_i | input | 1 | Global enable for servicing |
| ack_i | input | 1 | Acknowledge: service the selected level |
| eoi_i | input | 1 | End of interrupt: retire lowest in-service level |
| req_o | output | NUM_LEVELS | Request register |
| isr_o | output | NUM_LEVELS | In-service register |
| pend_o | output | NUM_LEVELS | Pending register |
| stat_o | output | 2*NUM_LEVELS | Per-level request status, 2 bits per level |
| irq_pending_o | output | 1 | An unmasked request exists |
| sel_level_o | output | $clog2(NUM_LEVELS) | Lowest unmasked requested level |

## Verification
The bench uses the default of eight levels. At that size the mixed-priority scenarios can hold several levels requested and in service at once. The top level 7 also exercises the highest status field and the widest selected-level code. The bench walks one level through accepted, queued and lost, and then through promotion after end of interrupt. It also covers a collision between promotion and a new request, and the cancel, mask and disabled-acknowledge cases, each with exact register values.

// File: rtl/irq_trk_pkg.sv
package irq_trk_pkg;

    typedef enum logic [1:0] {
        ST_NONE   = 2'd0,
        ST_ACCEPT = 2'd1,
        ST_QUEUED = 2'd2,
        ST_LOST   = 2'd3
    } req_stat_e;

    typedef struct packed {
        logic      req;
        logic      isr;
        logic      pend;
        req_stat_e stat;
    } lvl_state_t;

endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int WIDTH = 8,
    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic [WIDTH-1:0] vec_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [WIDTH-1:0] onehot_o
);

    always_comb begin
        idx_o = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IDX_W'(i);
        end
    end

    assign any_o    = |vec_i;
    assign onehot_o = vec_i & (~vec_i + WIDTH'(1));

endmodule

// File: rtl/irq_lvl_slice.sv
module irq_lvl_slice
    import irq_trk_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_i,
    input  logic      cancel_i,
    input  logic      svc_i,
    input  logic      eoi_i,
    output logic      req_o,
    output logic      isr_o,
    output logic      pend_o,
    output req_stat_e stat_o
);

    lvl_state_t st_d, st_q;
    logic       promote;
    logic       busy;

    always_comb begin
        st_d      = st_q;
        st_d.stat = ST_NONE;
        promote   = st_q.pend && !st_q.req && !st_q.isr;
        busy      = st_q.req || st_q.isr || promote;

        if (promote) begin
            st_d.req  = 1'b1;
            st_d.pend = 1'b0;
        end
        if (svc_i) begin
            st_d.req = 1'b0;
            st_d.isr = 1'b1;
        end
        if (eoi_i) begin
            st_d.isr = 1'b0;
        end

        if (cancel_i) begin
            st_d.req  = 1'b0;
            st_d.pend = 1'b0;
        end else if (req_i) begin
            if (!busy) begin
                st_d.req  = 1'b1;
                st_d.stat = ST_ACCEPT;
            end else if (st_q.pend && !promote) begin
                st_d.stat = ST_LOST;
            end else begin
                st_d.pend = 1'b1;
                st_d.stat = ST_QUEUED;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_o  = st_q.req;
    assign isr_o  = st_q.isr;
    assign pend_o = st_q.pend;
    assign stat_o = st_q.stat;

    assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !cancel_i && !req_o && !isr_o && !pend_o) |=> (req_o && stat_o == ST_ACCEPT));

    assert_lost_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !cancel_i && pend_o && (req_o || isr_o)) |=> (pend_o && stat_o == ST_LOST));

    assert_promote_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !req_o && !isr_o && !cancel_i) |=> req_o);

    assert_cancel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cancel_i |=> (!req_o && !pend_o && stat_o == ST_NONE));

    assert_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_o && isr_o));

endmodule

// File: rtl/irq_tracker.sv
module irq_tracker
    import irq_trk_pkg::*;
#(
    parameter int NUM_LEVELS = 8,
    localparam int LVL_W = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_LEVELS-1:0]   req_i,
    input  logic [NUM_LEVELS-1:0]   cancel_i,
    input  logic [NUM_LEVELS-1:0]   mask_i,
    input  logic                    int_en_i,
    input  logic                    ack_i,
    input  logic                    eoi_i,
    output logic [NUM_LEVELS-1:0]   req_o,
    output logic [NUM_LEVELS-1:0]   isr_o,
    output logic [NUM_LEVELS-1:0]   pend_o,
    output logic [2*NUM_LEVELS-1:0] stat_o,
    output logic                    irq_pending_o,
    output logic [LVL_W-1:0]        sel_level_o
);

    logic [NUM_LEVELS-1:0] live_req;
    logic [NUM_LEVELS-1:0] svc_oh;
    logic [NUM_LEVELS-1:0] isr_oh;
    logic [NUM_LEVELS-1:0] svc_vec;
    logic [NUM_LEVELS-1:0] eoi_vec;
    logic [LVL_W-1:0]      isr_idx;
    logic                  isr_any;
    logic                  svc_fire;

    assign live_req = req_o & ~mask_i;

    irq_prio_enc #(.WIDTH(NUM_LEVELS)) u_req_enc (
        .vec_i    (live_req),
        .any_o    (irq_pending_o),
        .idx_o    (sel_level_o),
        .onehot_o (svc_oh)
    );

    irq_prio_enc #(.WIDTH(NUM_LEVELS)) u_isr_enc (
        .vec_i    (isr_o),
        .any_o    (isr_any),
        .idx_o    (isr_idx),
        .onehot_o (isr_oh)
    );

    assign svc_fire = ack_i && int_en_i && irq_pending_o;
    assign svc_vec  = svc_fire ? svc_oh : '0;
    assign eoi_vec  = (eoi_i && isr_any) ? isr_oh : '0;

    for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_lvl
        req_stat_e lvl_stat;

        irq_lvl_slice u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .req_i    (req_i[g]),
            .cancel_i (cancel_i[g]),
            .svc_i    (svc_vec[g]),
            .eoi_i    (eoi_vec[g]),
            .req_o    (req_o[g]),
            .isr_o    (isr_o[g]),
            .pend_o   (pend_o[g]),
            .stat_o   (lvl_stat)
        );

        assign stat_o[2*g +: 2] = lvl_stat;
    end

    assert_svc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        svc_fire |=> ((isr_o & $past(svc_oh)) == $past(svc_oh)));

    assert_no_service_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !int_en_i |=> ((isr_o & ~$past(isr_o)) == '0));

    assert_eoi_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_i && isr_any && !svc_fire) |=>
            ($countones(isr_o) + 1 == $countones($past(isr_o))));

    assert_eoi_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_i && !isr_any && !svc_fire) |=> (isr_o == '0));

    assert_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pending_o |-> !mask_i[sel_level_o]);

    logic unused_isr_idx;
    assign unused_isr_idx = ^isr_idx;

endmodule

// File: tb/sim_irq_tracker.sv
`timescale 1ns/1ps
module sim_irq_tracker;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0, cancel = '0, mask = '0;
    logic         int_en = 1'b0, ack = 1'b0, eoi = 1'b0;
    logic [N-1:0] req_o, isr_o, pend_o;
    logic [2*N-1:0] stat_o;
    logic         irq_pending_o;
    logic [2:0]   sel_level_o;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    irq_tracker #(.NUM_LEVELS(N)) u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req), .cancel_i(cancel), .mask_i(mask),
        .int_en_i(int_en), .ack_i(ack), .eoi_i(eoi),
        .req_o(req_o), .isr_o(isr_o), .pend_o(pend_o), .stat_o(stat_o),
        .irq_pending_o(irq_pending_o), .sel_level_o(sel_level_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    function automatic logic [1:0] st(input int k);
        return stat_o[2*k +: 2];
    endfunction

    // apply pulses at a falling edge, let one rising edge pass, release them
    task automatic step(input logic [N-1:0] r, input logic [N-1:0] c,
                        input logic a, input logic e);
        req = r; cancel = c; ack = a; eoi = e;
        @(negedge clk);
        req = '0; cancel = '0; ack = 1'b0; eoi = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 reset req", 32'(req_o), 0);
        chk("R6 reset isr", 32'(isr_o), 0);
        chk("R2 reset pend", 32'(pend_o), 0);
        chk("R1 reset stat", 32'(stat_o), 0);
        chk("R6 reset flag", 32'(irq_pending_o), 0);
    endtask

    task automatic t_accept_queue_lost;
        step(8'h08, '0, 0, 0);
        chk("R1 accept req", 32'(req_o), 32'h08);
        chk("R1 accept stat", 32'(st(3)), 1);
        step(8'h08, '0, 0, 0);
        chk("R2 queued stat", 32'(st(3)), 2);
        chk("R2 queued pend", 32'(pend_o), 32'h08);
        step(8'h08, '0, 0, 0);
        chk("R2 lost stat", 32'(st(3)), 3);
        chk("R3 pend kept", 32'(pend_o), 32'h08);
        chk("R3 req kept", 32'(req_o), 32'h08);
        @(negedge clk);
        chk("R1 stat idle", 32'(st(3)), 0);
    endtask

    task automatic t_service_promote;
        chk("R6 flag", 32'(irq_pending_o), 1);
        chk("R6 sel", 32'(sel_level_o), 3);
        int_en = 1'b1;
        step('0, '0, 1, 0);
        chk("R6 isr set", 32'(isr_o), 32'h08);
        chk("R6 req clr", 32'(req_o), 0);
        chk("R4 held by isr", 32'(pend_o), 32'h08);
        step('0, '0, 0, 1);
        chk("R8 isr clr", 32'(isr_o), 0);
        chk("R4 not yet req", 32'(req_o), 0);
        chk("R4 not yet pend", 32'(pend_o), 32'h08);
        @(negedge clk);
        chk("R4 promoted req", 32'(req_o), 32'h08);
        chk("R4 promoted pend", 32'(pend_o), 0);
    endtask

    task automatic t_cancel;
        step('0, 8'h08, 0, 0);
        chk("R5 cancel req", 32'(req_o), 0);
        chk("R5 cancel pend", 32'(pend_o), 0);
        step('0, 8'h20, 0, 0);
        chk("R5 idle cancel", 32'({req_o, isr_o, pend_o}), 0);
        step(8'h04, 8'h04, 0, 0);
        chk("R5 cancel wins req", 32'(req_o), 0);
        chk("R5 cancel wins stat", 32'(st(2)), 0);
    endtask

    task automatic t_priority;
        step(8'hD2, '0, 0, 0);
        mask = 8'h02;
        #1;
        chk("R9 masked sel", 32'(sel_level_o), 4);
        int_en = 1'b0;
        step('0, '0, 1, 0);
        chk("R7 no service", 32'(isr_o), 0);
        chk("R7 flag while off", 32'(irq_pending_o), 1);
        int_en = 1'b1;
        step('0, '0, 1, 0);
        chk("R6 serve 4", 32'(isr_o), 32'h10);
        chk("R9 masked kept", 32'(req_o), 32'hC2);
        chk("R9 next sel", 32'(sel_level_o), 6);
        mask = 8'h00;
        step('0, '0, 1, 0);
        chk("R6 serve 1", 32'(isr_o), 32'h12);
        step('0, '0, 1, 0);
        step('0, '0, 1, 0);
        chk("R6 serve 7", 32'(isr_o), 32'hD2);
        chk("R6 empty flag", 32'(irq_pending_o), 0);
        step('0, '0, 0, 1);
        chk("R8 eoi lowest", 32'(isr_o), 32'hD0);
        step('0, '0, 0, 1);
        step('0, '0, 0, 1);
        step('0, '0, 0, 1);
        chk("R8 eoi top", 32'(isr_o), 0);
        step('0, '0, 0, 1);
        chk("R8 eoi none", 32'({req_o, isr_o, pend_o}), 0);
        step(8'h81, '0, 0, 0);
        mask = 8'hFF;
        #1;
        chk("R9 all masked flag", 32'(irq_pending_o), 0);
        mask = 8'h00;
        step('0, 8'h81, 0, 0);
    endtask

    task automatic t_promote_collision;
        step(8'h01, '0, 0, 0);
        step('0, '0, 1, 0);
        step(8'h01, '0, 0, 0);
        step('0, '0, 0, 1);
        step(8'h01, '0, 0, 0);
        chk("R4 collide req", 32'(req_o), 32'h01);
        chk("R4 collide pend", 32'(pend_o), 32'h01);
        chk("R4 collide stat", 32'(st(0)), 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_accept_queue_lost();
        t_service_promote();
        t_cancel();
        t_priority();
        t_promote_collision();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule